// File: doc/BRIEF.md
# Width-Converting Dual-Clock Simple Dual-Port RAM

This block is a two-port memory in which a write-only port and a read-only port work on separate clocks and present different data widths over one shared store. One port is the narrow side and the other the wide side. The wide side's width is the narrow side's width times a ratio of 1, 2, 4 or 8. The narrow side gets that many times more addresses, so both sides see the same number of stored bits. Writing narrow and reading wide packs words together (up-sizing). Writing wide and reading narrow splits them apart (down-sizing). Either way, the width conversion between the two clock domains comes with the storage, and no separate packing logic is needed.

The store is organised as one bank per narrow lane, all indexed by the wide address. A narrow access picks its lane with the low bits of its address. A wide access touches every lane at once. The read side registers its output, and a synchronous active-low reset clears that register. The stored contents are never reset.

Top module: `xwidth_ram`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en` at 1, the word on `wr_data` is stored at `wr_addr`; with `wr_en` at 0 the stored contents stay unchanged and the write-side controls are never unknown.
- R2: While `rd_rst_n` is 0 at a rising `rd_clk` edge, `rd_data` becomes zero after that edge and stays zero for as long as the reset is held.
- R3: Out of reset, `rd_data` shows the contents of the `rd_addr` sampled at the previous rising `rd_clk` edge (one cycle of read latency), and a new address may be given on every cycle.
- R4: The ratio L = wide width / narrow width must be 1, 2, 4 or 8. The wide side has `WIDE_AW` address bits, the narrow side has `WIDE_AW + log2(L)`, and every address on either side is reachable.
- R5: Narrow address {w, s} (s being the low log2(L) bits) is bits [s*N +: N] of wide word w, where N is the narrow width; s = 0 is the least significant lane.
- R6: When up-sizing, a wide read of word w returns the L narrow words written at narrow addresses w*L to w*L+L-1, the lowest address in the lowest lane.
- R7: When down-sizing, a narrow read at {w, s} returns lane s of the wide word last written at w.
- R8: A narrow write changes only its own lane of the wide word; the other lanes keep their values.
- R9: With L = 1 the block behaves as an ordinary simple dual-port RAM with equal widths and address widths.
- R10: Port A writes and port B reads that overlap in time on different locations do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Store `wr_data` at `wr_addr` on this edge |
| wr_addr | input | WR_AW | Write address (wide or narrow numbering by configuration) |
| wr_data | input | WR_DW | Write word |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rd_rst_n | input | 1 | Synchronous active-low clear of the read register |
| rd_addr | input | RD_AW | Read address |
| rd_data | output | RD_DW | Registered read word |

## Verification
A port A store and a port B fetch can happen in the same instant, since the two clocks drift against each other. The bench provokes this on the 8-to-64 configuration. It streams narrow writes into the upper half of the store while, in parallel, it issues back-to-back wide reads of the lower half. Every overlapping read must still return the older pattern. After the writes settle, reads of the upper half must show the new narrow words packed in the order of their addresses.

// File: rtl/xwidth_ram_pkg.sv
package xwidth_ram_pkg;

    // Which side of the memory is the narrow one.
    typedef enum logic [1:0] {
        SHAPE_EQUAL = 2'd0,  // both sides the same width
        SHAPE_UP    = 2'd1,  // narrow write, wide read
        SHAPE_DOWN  = 2'd2   // wide write, narrow read
    } shape_e;

    function automatic shape_e shape_of(input int wr_dw, input int rd_dw);
        if (wr_dw < rd_dw)      return SHAPE_UP;
        else if (wr_dw > rd_dw) return SHAPE_DOWN;
        else                    return SHAPE_EQUAL;
    endfunction

    function automatic int narrow_of(input int wr_dw, input int rd_dw);
        return (wr_dw < rd_dw) ? wr_dw : rd_dw;
    endfunction

    function automatic int lanes_of(input int wr_dw, input int rd_dw);
        return (wr_dw < rd_dw) ? rd_dw / wr_dw : wr_dw / rd_dw;
    endfunction

    function automatic bit ratio_ok(input int lanes);
        return (lanes == 1) || (lanes == 2) || (lanes == 4) || (lanes == 8);
    endfunction

endpackage

// File: rtl/xwidth_ram_wr_steer.sv
// Turns one write-port access into per-lane write strobes and data.
module xwidth_ram_wr_steer
    import xwidth_ram_pkg::*;
#(
    parameter shape_e SHAPE   = SHAPE_EQUAL,
    parameter int     NARROW  = 8,
    parameter int     LANES   = 1,
    parameter int     WIDE_AW = 6,
    parameter int     WR_DW   = 8,
    parameter int     WR_AW   = 6
) (
    input  logic                    wr_en,
    input  logic [WR_AW-1:0]        wr_addr,
    input  logic [WR_DW-1:0]        wr_data,
    output logic [LANES-1:0]        lane_we,
    output logic [WIDE_AW-1:0]      lane_addr,
    output logic [LANES*NARROW-1:0] lane_din
);

    localparam int SUB_BITS = (LANES > 1) ? $clog2(LANES) : 1;

    generate
        if (SHAPE == SHAPE_UP) begin : g_narrow_wr
            logic [SUB_BITS-1:0] sub;
            assign sub       = wr_addr[SUB_BITS-1:0];
            assign lane_addr = wr_addr[WR_AW-1:SUB_BITS];
            assign lane_din  = {LANES{wr_data}};
            for (genvar k = 0; k < LANES; k++) begin : g_sel
                assign lane_we[k] = wr_en && (sub == SUB_BITS'(k));
            end
        end else begin : g_wide_wr
            assign lane_addr = wr_addr;
            assign lane_din  = wr_data;
            assign lane_we   = {LANES{wr_en}};
        end
    endgenerate

endmodule

// File: rtl/xwidth_ram_lane.sv
// One narrow lane of storage, written on the write clock, read combinationally.
module xwidth_ram_lane #(
    parameter int NARROW  = 8,
    parameter int WIDE_AW = 6
) (
    input  logic               wr_clk,
    input  logic               we,
    input  logic [WIDE_AW-1:0] waddr,
    input  logic [NARROW-1:0]  din,
    input  logic [WIDE_AW-1:0] raddr,
    output logic [NARROW-1:0]  dout
);

    localparam int DEPTH = 1 << WIDE_AW;

    logic [NARROW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= din;
        end
    end

    assign dout = cells[raddr];

endmodule

// File: rtl/xwidth_ram_rd_steer.sv
// Picks the read lane(s) and registers the read word on the read clock.
module xwidth_ram_rd_steer
    import xwidth_ram_pkg::*;
#(
    parameter shape_e SHAPE   = SHAPE_EQUAL,
    parameter int     NARROW  = 8,
    parameter int     LANES   = 1,
    parameter int     WIDE_AW = 6,
    parameter int     RD_DW   = 8,
    parameter int     RD_AW   = 6
) (
    input  logic                    rd_clk,
    input  logic                    rd_rst_n,
    input  logic [RD_AW-1:0]        rd_addr,
    input  logic [LANES*NARROW-1:0] lane_dout,
    output logic [WIDE_AW-1:0]      lane_raddr,
    output logic [RD_DW-1:0]        rd_data
);

    localparam int SUB_BITS = (LANES > 1) ? $clog2(LANES) : 1;

    logic [RD_DW-1:0] rd_next;

    generate
        if (SHAPE == SHAPE_DOWN) begin : g_narrow_rd
            logic [SUB_BITS-1:0] sub;
            assign sub        = rd_addr[SUB_BITS-1:0];
            assign lane_raddr = rd_addr[RD_AW-1:SUB_BITS];
            assign rd_next    = lane_dout[int'(sub)*NARROW +: NARROW];
        end else begin : g_wide_rd
            assign lane_raddr = rd_addr;
            assign rd_next    = lane_dout;
        end
    endgenerate

    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/xwidth_ram.sv
// Dual-clock simple dual-port RAM with unequal port widths.
module xwidth_ram
    import xwidth_ram_pkg::*;
#(
    parameter int WR_DW   = 8,
    parameter int RD_DW   = 32,
    parameter int WIDE_AW = 6,
    // derived, not meant to be overridden
    parameter int WR_AW   = WIDE_AW +
        ((WR_DW < RD_DW) ? $clog2(lanes_of(WR_DW, RD_DW)) : 0),
    parameter int RD_AW   = WIDE_AW +
        ((RD_DW < WR_DW) ? $clog2(lanes_of(WR_DW, RD_DW)) : 0)
) (
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [WR_AW-1:0] wr_addr,
    input  logic [WR_DW-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic [RD_AW-1:0] rd_addr,
    output logic [RD_DW-1:0] rd_data
);

    localparam shape_e SHAPE  = shape_of(WR_DW, RD_DW);
    localparam int     NARROW = narrow_of(WR_DW, RD_DW);
    localparam int     LANES  = lanes_of(WR_DW, RD_DW);

    generate
        if (!ratio_ok(LANES)) begin : g_bad_ratio
            $error("xwidth_ram: width ratio must be 1, 2, 4 or 8");
        end
    endgenerate

    logic [LANES-1:0]        lane_we;
    logic [WIDE_AW-1:0]      lane_waddr;
    logic [LANES*NARROW-1:0] lane_din;
    logic [WIDE_AW-1:0]      lane_raddr;
    logic [LANES*NARROW-1:0] lane_dout;

    xwidth_ram_wr_steer #(
        .SHAPE   (SHAPE),
        .NARROW  (NARROW),
        .LANES   (LANES),
        .WIDE_AW (WIDE_AW),
        .WR_DW   (WR_DW),
        .WR_AW   (WR_AW)
    ) u_wr_steer (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .lane_we   (lane_we),
        .lane_addr (lane_waddr),
        .lane_din  (lane_din)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            xwidth_ram_lane #(
                .NARROW  (NARROW),
                .WIDE_AW (WIDE_AW)
            ) u_lane (
                .wr_clk (wr_clk),
                .we     (lane_we[k]),
                .waddr  (lane_waddr),
                .din    (lane_din[k*NARROW +: NARROW]),
                .raddr  (lane_raddr),
                .dout   (lane_dout[k*NARROW +: NARROW])
            );
        end
    endgenerate

    xwidth_ram_rd_steer #(
        .SHAPE   (SHAPE),
        .NARROW  (NARROW),
        .LANES   (LANES),
        .WIDE_AW (WIDE_AW),
        .RD_DW   (RD_DW),
        .RD_AW   (RD_AW)
    ) u_rd_steer (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .rd_addr    (rd_addr),
        .lane_dout  (lane_dout),
        .lane_raddr (lane_raddr),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/xwidth_ram_chk.sv
// Checker: keeps a narrow-unit shadow of the store and compares reads against it.
module xwidth_ram_chk
    import xwidth_ram_pkg::*;
#(
    parameter int WR_DW   = 8,
    parameter int RD_DW   = 32,
    parameter int WIDE_AW = 6,
    parameter int WR_AW   = 6,
    parameter int RD_AW   = 8
) (
    input logic             wr_clk,
    input logic             wr_en,
    input logic [WR_AW-1:0] wr_addr,
    input logic [WR_DW-1:0] wr_data,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic [RD_AW-1:0] rd_addr,
    input logic [RD_DW-1:0] rd_data
);

    localparam shape_e SHAPE  = shape_of(WR_DW, RD_DW);
    localparam int     NARROW = narrow_of(WR_DW, RD_DW);
    localparam int     LANES  = lanes_of(WR_DW, RD_DW);
    localparam int     UNITS  = LANES << WIDE_AW;

    logic [NARROW-1:0] shadow [UNITS];
    logic [UNITS-1:0]  shadow_ok = '0;
    logic              wr_seen   = 1'b0;
    logic              rd_seen   = 1'b0;
    logic [RD_DW-1:0]  exp_next;
    logic              ok_next;
    logic [RD_DW-1:0]  exp_q     = '0;
    logic              ok_q      = 1'b0;

    always_ff @(posedge wr_clk) begin
        wr_seen <= 1'b1;
        if (wr_en) begin
            if (SHAPE == SHAPE_DOWN) begin
                for (int k = 0; k < LANES; k++) begin
                    shadow[int'(wr_addr) * LANES + k]    <= wr_data[k*NARROW +: NARROW];
                    shadow_ok[int'(wr_addr) * LANES + k] <= 1'b1;
                end
            end else begin
                shadow[int'(wr_addr)]    <= wr_data[NARROW-1:0];
                shadow_ok[int'(wr_addr)] <= 1'b1;
            end
        end
    end

    always_comb begin
        exp_next = '0;
        ok_next  = 1'b1;
        if (SHAPE == SHAPE_UP) begin
            for (int k = 0; k < LANES; k++) begin
                exp_next[k*NARROW +: NARROW] = shadow[int'(rd_addr) * LANES + k];
                ok_next = ok_next && shadow_ok[int'(rd_addr) * LANES + k];
            end
        end else begin
            exp_next[NARROW-1:0] = shadow[int'(rd_addr)];
            ok_next = shadow_ok[int'(rd_addr)];
        end
    end

    always_ff @(posedge rd_clk) begin
        rd_seen <= 1'b1;
        if (!rd_rst_n) begin
            ok_q <= 1'b0;
        end else begin
            ok_q  <= ok_next;
            exp_q <= exp_next;
        end
    end

    // R1: write controls are defined, address defined when writing
    p_wr_ctrl_known_r1: assert property (@(posedge wr_clk) disable iff (!wr_seen)
        !$isunknown(wr_en) && (!wr_en || !$isunknown(wr_addr)));

    // R2: reset clears the read register at the next edge
    p_rst_clears_r2: assert property (@(posedge rd_clk) disable iff (!rd_seen)
        !rd_rst_n |=> rd_data == '0);

    // R3: read address must be defined while out of reset
    p_rd_addr_known_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !$isunknown(rd_addr));

    // R5 R6 R7: registered read matches the lane-mapped shadow one cycle later
    p_lane_map_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ok_q |-> rd_data == exp_q);

endmodule

bind xwidth_ram xwidth_ram_chk #(
    .WR_DW   (WR_DW),
    .RD_DW   (RD_DW),
    .WIDE_AW (WIDE_AW),
    .WR_AW   (WR_AW),
    .RD_AW   (RD_AW)
) u_chk (
    .wr_clk   (wr_clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/xwidth_ram_test.sv
`timescale 1ns/1ps
module xwidth_ram_test;

    localparam int NCFG = 7;
    localparam int WAW  = 3;
    // config: 0 equal, 1..3 up-size x2/x4/x8, 4..6 down-size x2/x4/x8
    localparam int C_WR [NCFG] = '{16, 8, 8, 8, 16, 32, 64};
    localparam int C_RD [NCFG] = '{16, 16, 32, 64, 8, 8, 8};

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        we  [NCFG];
    logic [5:0]  wa  [NCFG];
    logic [63:0] wd  [NCFG];
    logic [5:0]  ra  [NCFG];
    logic [63:0] rdv [NCFG];

    int checks = 0;
    int fails  = 0;

    initial forever #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #6.5 rd_clk = ~rd_clk;
    end

    initial begin
        for (int c = 0; c < NCFG; c++) begin
            we[c] = 1'b0; wa[c] = '0; wd[c] = '0; ra[c] = '0;
        end
    end

    generate
        for (genvar c = 0; c < NCFG; c++) begin : g_cfg
            localparam int WDW = C_WR[c];
            localparam int RDW = C_RD[c];
            localparam int LG  = (WDW > RDW) ? $clog2(WDW / RDW) : $clog2(RDW / WDW);
            localparam int WA  = WAW + ((WDW < RDW) ? LG : 0);
            localparam int RA  = WAW + ((RDW < WDW) ? LG : 0);
            logic [RDW-1:0] rdo;
            xwidth_ram #(.WR_DW(WDW), .RD_DW(RDW), .WIDE_AW(WAW)) uut (
                .wr_clk   (wr_clk),
                .wr_en    (we[c]),
                .wr_addr  (wa[c][WA-1:0]),
                .wr_data  (wd[c][WDW-1:0]),
                .rd_clk   (rd_clk),
                .rd_rst_n (rd_rst_n),
                .rd_addr  (ra[c][RA-1:0]),
                .rd_data  (rdo)
            );
            assign rdv[c] = 64'(rdo);
        end
    endgenerate

    function automatic int nw(int c);
        return (C_WR[c] < C_RD[c]) ? C_WR[c] : C_RD[c];
    endfunction

    function automatic int lanes(int c);
        return (C_WR[c] < C_RD[c]) ? C_RD[c] / C_WR[c] : C_WR[c] / C_RD[c];
    endfunction

    function automatic bit wr_wide(int c);
        return C_WR[c] > C_RD[c];
    endfunction

    function automatic bit rd_wide(int c);
        return C_RD[c] > C_WR[c];
    endfunction

    function automatic int port_words(bit wide, int c);
        return (wide || lanes(c) == 1) ? (1 << WAW) : ((1 << WAW) * lanes(c));
    endfunction

    // Pattern for one narrow unit.
    function automatic logic [63:0] unit_val(int c, int seed, int idx);
        logic [15:0] u;
        u = 16'(seed * 40503 + idx * 257 + c * 97 + 16'h1357);
        return 64'(u) & ((64'd1 << nw(c)) - 64'd1);
    endfunction

    // Word seen at address a of a port: lane k of a wide word = unit a*L+k.
    function automatic logic [63:0] port_val(int c, int seed, int a, bit wide);
        logic [63:0] v;
        v = '0;
        if (!wide) return unit_val(c, seed, a);
        for (int k = 0; k < lanes(c); k++) begin
            v = v | (unit_val(c, seed, a * lanes(c) + k) << (k * nw(c)));
        end
        return v;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(int c, int seed, int first, int count);
        for (int a = first; a < first + count; a++) begin
            @(negedge wr_clk);
            we[c] = 1'b1;
            wa[c] = 6'(a);
            wd[c] = port_val(c, seed, a, wr_wide(c));
        end
        @(negedge wr_clk);
        we[c] = 1'b0;
        repeat (2) @(negedge rd_clk);
    endtask

    // Back-to-back reads, one new address per read cycle (R3).
    task automatic read_seq(int c, int seed, int first, int count, string req);
        logic [63:0] exp_prev;
        exp_prev = '0;
        for (int i = 0; i <= count; i++) begin
            @(negedge rd_clk);
            if (i > 0) check(req, rdv[c], exp_prev);
            if (i < count) begin
                ra[c]    = 6'(first + i);
                exp_prev = port_val(c, seed, first + i, rd_wide(c));
            end
        end
    endtask

    task automatic read_one(int c, int a, logic [63:0] exp, string req);
        @(negedge rd_clk);
        ra[c] = 6'(a);
        @(negedge rd_clk);
        check(req, rdv[c], exp);
    endtask

    task automatic t_reset_state;
        repeat (3) @(negedge rd_clk);
        for (int c = 0; c < NCFG; c++) check("R2 reset output", rdv[c], 64'd0);
        rd_rst_n = 1'b1;
    endtask

    task automatic t_ratio_sweep;
        for (int c = 0; c < NCFG; c++) begin
            fill(c, c + 1, 0, port_words(wr_wide(c), c));
            if (c == 0)
                read_seq(c, c + 1, 0, port_words(rd_wide(c), c), "R9 R1 equal widths");
            else if (rd_wide(c))
                read_seq(c, c + 1, 0, port_words(1'b1, c), "R6 R5 R4 up-size");
            else
                read_seq(c, c + 1, 0, port_words(1'b0, c), "R7 R5 R4 down-size");
        end
    endtask

    task automatic t_lane_overwrite;
        logic [63:0] old;
        old = port_val(2, 3, 2, 1'b1);
        @(negedge wr_clk);
        we[2] = 1'b1; wa[2] = 6'd9; wd[2] = 64'hA5;
        @(negedge wr_clk);
        we[2] = 1'b0;
        repeat (2) @(negedge rd_clk);
        read_one(2, 2, (old & ~(64'hFF << 8)) | (64'hA5 << 8), "R8 single lane write");
        read_one(2, 3, port_val(2, 3, 3, 1'b1), "R8 neighbour word kept");
        @(negedge wr_clk);
        we[5] = 1'b1; wa[5] = 6'd6; wd[5] = 64'hC3B2A190;
        @(negedge wr_clk);
        we[5] = 1'b0;
        repeat (2) @(negedge rd_clk);
        read_one(5, 24, 64'h90, "R7 lane 0");
        read_one(5, 25, 64'hA1, "R7 lane 1");
        read_one(5, 26, 64'hB2, "R7 lane 2");
        read_one(5, 27, 64'hC3, "R7 lane 3");
    endtask

    task automatic t_wen_low;
        @(negedge wr_clk);
        we[1] = 1'b0; wa[1] = 6'd3; wd[1] = 64'h5A;
        repeat (2) @(negedge wr_clk);
        repeat (2) @(negedge rd_clk);
        read_one(1, 1, port_val(1, 2, 1, 1'b1), "R1 disabled write ignored");
    endtask

    task automatic t_reset_again;
        @(negedge rd_clk);
        ra[4] = 6'd5;
        @(negedge rd_clk);
        check("R3 data before reset", rdv[4], port_val(4, 5, 5, 1'b0));
        rd_rst_n = 1'b0;
        @(negedge rd_clk);
        check("R2 cleared", rdv[4], 64'd0);
        @(negedge rd_clk);
        check("R2 held clear", rdv[4], 64'd0);
        rd_rst_n = 1'b1;
        @(negedge rd_clk);
        check("R3 data after release", rdv[4], port_val(4, 5, 5, 1'b0));
    endtask

    task automatic t_concurrent;
        fork
            fill(3, 9, 32, 32);
            begin
                for (int i = 0; i < 24; i++) begin
                    read_seq(3, 4, i % 4, 1, "R10 old data during writes");
                end
            end
        join
        read_seq(3, 9, 4, 4, "R10 new data after writes");
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ratio_sweep();
        t_lane_overwrite();
        t_wen_low();
        t_reset_again();
        t_concurrent();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule